// File: doc/BRIEF.md
# Synthetic-result ADC register block

This block is a bus-slave register file that presents the programming model of a simple successive-approximation ADC controller. It produces no real samples. Instead, each read of the regular data register acts as one conversion and yields a synthetic value. The block exists so that firmware and system tests can drive an ADC driver against hardware that answers sensibly, even where no analog front end is present.

The host reaches the block through a plain synchronous port. An access is one cycle with `bus_rd` or `bus_wr` high. Read data is registered: it appears on `bus_rdata` after the clock edge that samples the read strobe, and it holds there until the next read.

The registers are status, two controls, two sample-time registers, four injected offsets, high and low thresholds, three regular-sequence registers, an injected-sequence register, four injected data registers and the regular data register.

Conversions are one-shot. A small state machine owns the software-start flag. It has two states:
- ST_IDLE: no conversion is pending.
- ST_ARMED: one conversion is pending.

It moves between them on three transitions:
- T_ARM: a control-2 write with bit 30 set moves the machine to ST_ARMED.
- T_DISARM: a control-2 write with bit 30 clear moves it to ST_IDLE.
- T_FIRE: a data-register read while the converter is on and the machine is in ST_ARMED moves it to ST_IDLE.

If a control-2 write and a firing read fall in the same cycle, the write decides the next state.

Top module: `synth_adc_regs`

## Requirements
- R1: After reset every register reads 0, except the high threshold at offset 0x24, which reads 0x00000FFF; the injected data registers read 0.
- R2: A read of offset 0x4C fires a conversion when control-2 bit 0 (converter on) is set and a start is pending. A start is pending after a control-2 write with bit 30 set. A conversion does three things:
  - it adds 7 to the stored value, modulo 2^32;
  - it masks the sum to the selected resolution and stores the result;
  - it returns that result.
- R3: A read of 0x4C with the converter off, or with no start pending, returns 0 and leaves the stored value unchanged.
- R4: Control-1 bits 25:24 select the resolution mask: 0 gives 0xFFF, 1 gives 0x3FF, 2 gives 0xFF and 3 gives 0x3F.
- R5: When control-2 bit 11 is set, the value returned by a conversion is (stored << 1) & 0xFFF0. When bit 11 is clear, the stored value is returned as is.
- R6: A write to status (0x00) ANDs the current value with the low 6 bits of the written data. No event in this block sets status, so status reads 0 after any write.
- R7: A read of control-2 (0x08) returns only bits 27:0 of the last written value, so bit 30 never reads as 1.
- R8: The injected offsets at 0x14, 0x18, 0x1C and 0x20 keep only the low 12 bits of a write. A read of injected data register n (0x3C + 4n) returns its stored value minus offset n, modulo 2^32.
- R9: The following registers store and return full 32-bit values:
  - control-1 (0x04);
  - the sample-time registers (0x0C, 0x10);
  - the thresholds (0x24, 0x28);
  - the sequence registers (0x2C, 0x30, 0x34, 0x38);
  - the injected data registers (written raw).
- R10: A read of any other offset, including offsets that are not word aligned, returns 0. A write to any such offset changes no register.
- R11: The `irq` output is 0 at all times.
- R12: Each start is consumed by one conversion. A second read of 0x4C with no new start write returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after the read strobe |
| irq | output | 1 | Interrupt request, always low |

## Verification
The hardest state to reach is the wrap of the synthetic counter at each resolution. The counter only moves through an arm-then-read pair, and at 12 bits it takes about 585 conversions to pass the mask boundary. The stimulus therefore loops hundreds of arm/read pairs at 12 bits, then switches resolution and alignment mid-run. Each switch leaves a stored value that was masked under the previous setting. A shadow model, kept from the written control values alone, predicts every returned value. It also confirms that reads made while disarmed or powered off neither return data nor move the counter.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
    localparam int unsigned REG_W    = 32;
    localparam int unsigned ADDR_W   = 8;
    localparam int unsigned N_INJ    = 4;
    localparam int unsigned INJ_OFSW = 12;
    localparam int unsigned STAT_W   = 6;
    localparam int unsigned STEP     = 7;

    localparam logic [ADDR_W-1:0] A_STAT  = 8'h00;
    localparam logic [ADDR_W-1:0] A_CTL1  = 8'h04;
    localparam logic [ADDR_W-1:0] A_CTL2  = 8'h08;
    localparam logic [ADDR_W-1:0] A_SMP1  = 8'h0C;
    localparam logic [ADDR_W-1:0] A_SMP2  = 8'h10;
    localparam logic [ADDR_W-1:0] A_IOFS0 = 8'h14;
    localparam logic [ADDR_W-1:0] A_HIGH  = 8'h24;
    localparam logic [ADDR_W-1:0] A_LOW   = 8'h28;
    localparam logic [ADDR_W-1:0] A_SEQ1  = 8'h2C;
    localparam logic [ADDR_W-1:0] A_SEQ2  = 8'h30;
    localparam logic [ADDR_W-1:0] A_SEQ3  = 8'h34;
    localparam logic [ADDR_W-1:0] A_ISEQ  = 8'h38;
    localparam logic [ADDR_W-1:0] A_IDAT0 = 8'h3C;
    localparam logic [ADDR_W-1:0] A_DATA  = 8'h4C;

    localparam logic [REG_W-1:0] HIGH_RST = 32'h0000_0FFF;

    localparam int unsigned B_ON    = 0;
    localparam int unsigned B_ALIGN = 11;
    localparam int unsigned B_START = 30;
    localparam int unsigned B_RES   = 24;
    localparam int unsigned CTL2_RD_W = 28;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } start_state_t;

    function automatic logic [REG_W-1:0] res_mask(input logic [1:0] sel);
        logic [REG_W-1:0] m;
        unique case (sel)
            2'd0: m = 32'h0000_0FFF;
            2'd1: m = 32'h0000_03FF;
            2'd2: m = 32'h0000_00FF;
            default: m = 32'h0000_003F;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/sadc_start_fsm.sv
module sadc_start_fsm
    import sadc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl2_wr_i,
    input  logic start_bit_i,
    input  logic dr_rd_i,
    input  logic on_i,
    output logic armed_o,
    output logic conv_o
);
    start_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: T_ARM, T_DISARM (writes win), T_FIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ctl2_wr_i && start_bit_i) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (ctl2_wr_i)                state_d = start_bit_i ? ST_ARMED : ST_IDLE;
                else if (dr_rd_i && on_i)     state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        armed_o = (state_q == ST_ARMED);
        conv_o  = armed_o && dr_rd_i && on_i;
    end

    // R12: a fired conversion leaves the machine idle unless re-armed in the same cycle
    a_r12_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        conv_o |=> (!armed_o || $past(ctl2_wr_i && start_bit_i)));
endmodule

// File: rtl/sadc_data_gen.sv
module sadc_data_gen
    import sadc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_i,
    input  logic [1:0]       res_i,
    input  logic             align_i,
    output logic [REG_W-1:0] result_o
);
    logic [REG_W-1:0] stored_q;
    logic [REG_W-1:0] stepped;

    always_comb begin
        stepped  = (stored_q + REG_W'(STEP)) & res_mask(res_i);
        result_o = align_i ? ((stepped << 1) & 32'h0000_FFF0) : stepped;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      stored_q <= '0;
        else if (conv_i) stored_q <= stepped;
    end

    // R4: after a conversion the stored value fits the resolution in force then
    a_r4_masked: assert property (@(posedge clk) disable iff (!rst_n)
        conv_i |=> ((stored_q & ~res_mask($past(res_i))) == '0));
    // R3: without a conversion the stored value does not move
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_i |=> $stable(stored_q));
endmodule

// File: rtl/sadc_inj_bank.sv
module sadc_inj_bank
    import sadc_pkg::*;
#(
    parameter int unsigned N    = N_INJ,
    parameter int unsigned OFSW = INJ_OFSW
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N-1:0]            ofs_wr_i,
    input  logic [N-1:0]            dat_wr_i,
    input  logic [REG_W-1:0]        wdata_i,
    output logic [N-1:0][REG_W-1:0] ofs_rd_o,
    output logic [N-1:0][REG_W-1:0] dat_rd_o
);
    localparam int unsigned PAD = REG_W - OFSW;

    for (genvar i = 0; i < N; i++) begin : g_ent
        logic [OFSW-1:0]  ofs_q;
        logic [REG_W-1:0] dat_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ofs_q <= '0;
                dat_q <= '0;
            end else begin
                if (ofs_wr_i[i]) ofs_q <= wdata_i[OFSW-1:0];
                if (dat_wr_i[i]) dat_q <= wdata_i;
            end
        end

        always_comb begin
            ofs_rd_o[i] = {{PAD{1'b0}}, ofs_q};
            dat_rd_o[i] = dat_q - {{PAD{1'b0}}, ofs_q};
        end
    end
endmodule

// File: rtl/synth_adc_regs.sv
module synth_adc_regs
    import sadc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              irq
);
    localparam int unsigned TOP_PAD = REG_W - CTL2_RD_W;

    logic [REG_W-1:0] stat_q, ctl1_q, ctl2_q, smp1_q, smp2_q;
    logic [REG_W-1:0] high_q, low_q, seq1_q, seq2_q, seq3_q, iseq_q;
    logic [N_INJ-1:0] ofs_wr, dat_wr;
    logic [N_INJ-1:0][REG_W-1:0] ofs_rd, dat_rd;
    logic [REG_W-1:0] conv_val, rd_mux;
    logic dr_rd, ctl2_wr, conv, armed;

    assign dr_rd   = bus_rd && (bus_addr == A_DATA);
    assign ctl2_wr = bus_wr && (bus_addr == A_CTL2);
    assign irq     = 1'b0;

    for (genvar i = 0; i < N_INJ; i++) begin : g_dec
        assign ofs_wr[i] = bus_wr && (bus_addr == A_IOFS0 + ADDR_W'(4 * i));
        assign dat_wr[i] = bus_wr && (bus_addr == A_IDAT0 + ADDR_W'(4 * i));
    end

    sadc_start_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl2_wr_i   (ctl2_wr),
        .start_bit_i (bus_wdata[B_START]),
        .dr_rd_i     (dr_rd),
        .on_i        (ctl2_q[B_ON]),
        .armed_o     (armed),
        .conv_o      (conv)
    );

    sadc_data_gen u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .conv_i   (conv),
        .res_i    (ctl1_q[B_RES+1:B_RES]),
        .align_i  (ctl2_q[B_ALIGN]),
        .result_o (conv_val)
    );

    sadc_inj_bank u_inj (
        .clk      (clk),
        .rst_n    (rst_n),
        .ofs_wr_i (ofs_wr),
        .dat_wr_i (dat_wr),
        .wdata_i  (bus_wdata),
        .ofs_rd_o (ofs_rd),
        .dat_rd_o (dat_rd)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0; ctl1_q <= '0; ctl2_q <= '0; smp1_q <= '0;
            smp2_q <= '0; high_q <= HIGH_RST; low_q <= '0; seq1_q <= '0;
            seq2_q <= '0; seq3_q <= '0; iseq_q <= '0;
        end else if (bus_wr) begin
            unique case (bus_addr)
                A_STAT: stat_q <= stat_q & {{(REG_W-STAT_W){1'b0}}, bus_wdata[STAT_W-1:0]};
                A_CTL1: ctl1_q <= bus_wdata;
                A_CTL2: ctl2_q <= bus_wdata;
                A_SMP1: smp1_q <= bus_wdata;
                A_SMP2: smp2_q <= bus_wdata;
                A_HIGH: high_q <= bus_wdata;
                A_LOW:  low_q  <= bus_wdata;
                A_SEQ1: seq1_q <= bus_wdata;
                A_SEQ2: seq2_q <= bus_wdata;
                A_SEQ3: seq3_q <= bus_wdata;
                A_ISEQ: iseq_q <= bus_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (bus_addr)
            A_STAT: rd_mux = stat_q;
            A_CTL1: rd_mux = ctl1_q;
            A_CTL2: rd_mux = {{TOP_PAD{1'b0}}, ctl2_q[CTL2_RD_W-1:0]};
            A_SMP1: rd_mux = smp1_q;
            A_SMP2: rd_mux = smp2_q;
            A_HIGH: rd_mux = high_q;
            A_LOW:  rd_mux = low_q;
            A_SEQ1: rd_mux = seq1_q;
            A_SEQ2: rd_mux = seq2_q;
            A_SEQ3: rd_mux = seq3_q;
            A_ISEQ: rd_mux = iseq_q;
            A_DATA: rd_mux = conv ? conv_val : '0;
            default: rd_mux = '0;
        endcase
        for (int i = 0; i < N_INJ; i++) begin
            if (bus_addr == A_IOFS0 + ADDR_W'(4 * i)) rd_mux = ofs_rd[i];
            if (bus_addr == A_IDAT0 + ADDR_W'(4 * i)) rd_mux = dat_rd[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    // R3: a data read that does not fire a conversion returns 0
    a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_rd && !(armed && ctl2_q[B_ON])) |=> (bus_rdata == '0));
    // R7: the top control-2 bits never read back
    a_r7_ctl2_top: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_CTL2) |=> (bus_rdata[REG_W-1:CTL2_RD_W] == '0));
    // R6: status bits can only be cleared, never gained
    a_r6_stat_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & ~$past(stat_q)) == '0));
endmodule

// File: tb/synth_adc_regs_tb_top.sv
`timescale 1ns/1ps
module synth_adc_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    always #2.5 clk = ~clk;

    synth_adc_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    typedef struct { logic [31:0] exp; logic [7:0] addr; string tag; } item_t;
    item_t sb_q[$];
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // shadow model, driven only by written control values
    logic [31:0] m_dr = '0;
    logic [1:0]  m_res = '0;
    bit m_on = 0, m_align = 0, m_armed = 0;

    function automatic logic [31:0] mask_of(input logic [1:0] r);
        case (r)
            2'd0: return 32'hFFF;
            2'd1: return 32'h3FF;
            2'd2: return 32'hFF;
            default: return 32'h3F;
        endcase
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == 8'h04) m_res = d[25:24];
        if (a == 8'h08) begin m_on = d[0]; m_align = d[11]; m_armed = d[30]; end
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        it.exp = e; it.addr = a; it.tag = tag;
        sb_q.push_back(it);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic dr_read(input string tag);
        logic [31:0] e;
        if (m_on && m_armed) begin
            m_dr = (m_dr + 32'd7) & mask_of(m_res);
            m_armed = 0;
            e = m_align ? ((m_dr << 1) & 32'hFFF0) : m_dr;
        end else e = '0;
        rd_chk(8'h4C, e, tag);
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] e, input string tag);
        n_tests++;
        if (act !== e) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, e);
        end
    endtask

    // monitor: pop expected item one cycle after each sampled read strobe
    initial begin
        forever begin
            @(posedge clk);
            if (bus_rd) begin
                @(negedge clk);
                if (sb_q.size() == 0) chk(32'hDEAD, 32'h0, "SB empty");
                else begin
                    item_t it;
                    it = sb_q.pop_front();
                    chk(bus_rdata, it.exp, $sformatf("%s addr=%h", it.tag, it.addr));
                end
            end
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        for (int a = 0; a <= 8'h48; a += 4)
            rd_chk(8'(a), (a == 8'h24) ? 32'hFFF : 32'h0, "R1 reset");
        chk({31'b0, irq}, 32'h0, "R11 irq after reset");
        // R3 off / not armed
        dr_read("R3 off");
        wr(8'h08, 32'h4000_0000);
        dr_read("R3 armed but off");
        wr(8'h08, 32'h0000_0001);
        dr_read("R3 on but not armed");
        // R2 first conversion, R12 one-shot
        wr(8'h08, 32'h4000_0001);
        dr_read("R2 first conversion");
        dr_read("R12 second read without start");
        // R7 control-2 readback
        wr(8'h08, 32'hF000_0801);
        rd_chk(8'h08, 32'h0000_0801, "R7 ctl2 top bits");
        wr(8'h08, 32'h0000_0001);
        // R2/R4 long run at 12 bits past wrap
        for (int k = 0; k < 600; k++) begin
            wr(8'h08, 32'h4000_0001);
            dr_read("R4 12-bit run");
        end
        for (int r = 1; r < 4; r++) begin
            wr(8'h04, 32'(r) << 24);
            for (int k = 0; k < 45; k++) begin
                wr(8'h08, 32'h4000_0001);
                dr_read($sformatf("R4 res %0d", r));
            end
        end
        // R5 alignment
        wr(8'h04, 32'h0);
        for (int k = 0; k < 40; k++) begin
            wr(8'h08, 32'h4000_0801);
            dr_read("R5 aligned");
        end
        // R6 status
        wr(8'h00, 32'hFFFF_FFFF);
        rd_chk(8'h00, 32'h0, "R6 status ones");
        wr(8'h00, 32'h0);
        rd_chk(8'h00, 32'h0, "R6 status zero");
        // R8 injected
        wr(8'h14, 32'hFFFF_F123);
        rd_chk(8'h14, 32'h123, "R8 offset width");
        wr(8'h3C, 32'h1000);
        rd_chk(8'h3C, 32'h1000 - 32'h123, "R8 data minus offset");
        wr(8'h20, 32'h0000_0ABC);
        rd_chk(8'h48, 32'h0 - 32'hABC, "R8 wrap");
        rd_chk(8'h40, 32'h0, "R8 untouched entry");
        // R9 full-width registers
        wr(8'h04, 32'hA5A5_5A5A);
        rd_chk(8'h04, 32'hA5A5_5A5A, "R9 ctl1");
        wr(8'h0C, 32'h1234_5678); rd_chk(8'h0C, 32'h1234_5678, "R9 smp1");
        wr(8'h10, 32'h8765_4321); rd_chk(8'h10, 32'h8765_4321, "R9 smp2");
        wr(8'h24, 32'hFFFF_0001); rd_chk(8'h24, 32'hFFFF_0001, "R9 high");
        wr(8'h28, 32'hC0DE_0002); rd_chk(8'h28, 32'hC0DE_0002, "R9 low");
        wr(8'h2C, 32'h0BAD_F00D); rd_chk(8'h2C, 32'h0BAD_F00D, "R9 seq1");
        wr(8'h30, 32'hDEAD_BEEF); rd_chk(8'h30, 32'hDEAD_BEEF, "R9 seq2");
        wr(8'h34, 32'h5555_AAAA); rd_chk(8'h34, 32'h5555_AAAA, "R9 seq3");
        wr(8'h38, 32'hFEED_FACE); rd_chk(8'h38, 32'hFEED_FACE, "R9 iseq");
        wr(8'h44, 32'h8000_0000); rd_chk(8'h44, 32'h8000_0000, "R9 idat raw");
        // R10 unlisted offsets
        wr(8'h50, 32'hFFFF_FFFF);
        wr(8'h26, 32'hFFFF_FFFF);
        wr(8'hFC, 32'hFFFF_FFFF);
        rd_chk(8'h50, 32'h0, "R10 read 0x50");
        rd_chk(8'h26, 32'h0, "R10 read unaligned");
        rd_chk(8'hFC, 32'h0, "R10 read 0xFC");
        rd_chk(8'h24, 32'hFFFF_0001, "R10 neighbour unchanged");
        rd_chk(8'h28, 32'hC0DE_0002, "R10 neighbour low unchanged");
        chk({31'b0, irq}, 32'h0, "R11 irq at end");
        repeat (3) @(negedge clk);
        chk(32'(sb_q.size()), 32'h0, "SB drained");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule